// File: doc/BRIEF.md
# SPI Configuration Register Slave

This block lets an external controller on a four-wire SPI link (chip select, serial clock, data in, data out) read and write a bank of byte-wide configuration registers. The pins are oversampled by the system clock. Each frame opens with an instruction byte and then an address byte. Data bytes follow these two. The instruction picks between read and write, and between single access and burst access. A single access moves one byte and then expects a fresh instruction within the same frame. A burst access keeps stepping the address by one for every data byte until chip select rises.

Stored registers are presented to the rest of the chip as one flat parallel vector. One address works as a software-reset trigger. A write to that address clears every stored register and aborts the frame. It also raises a reset output that falls again at the next serial-clock rising edge or the next chip-select rising edge, whichever comes first.

Top module: `spi_cfg_slave`

## Requirements
- R1: Bits are sampled on SCLK rising edges, MSB first. A frame carries an instruction byte, then an address byte, then data. Instruction 0x01 (single write) stores its data byte at the stored register with that address.
- R2: After a single write completes, the next byte in the same frame is read as a new instruction. Several instruction/address/data groups can therefore be chained inside one chip-select window.
- R3: Instruction 0x03 (burst write) stores the first data byte at the start address. Each later data byte goes to the next higher address.
- R4: Instruction 0x02 (single read) drives the addressed register MSB first on MISO. Each bit changes only on an SCLK falling edge, so it is valid at the following rising edge.
- R5: Instruction 0x04 (burst read) returns consecutive addresses starting at the start address. After address 0xFF the address wraps to 0x00.
- R6: MOSI has no effect while read data is being driven. The instruction and address of a burst stay fixed until chip select goes high.
- R7: Addresses 0x0A through 0x23 are stored. Writes to any other address except 0x09 are discarded, and reads of any address outside 0x0A..0x23 return 0x00.
- R8: A write to address 0x09 clears all stored registers to 0x00, raises sw_rst_o and aborts the rest of the frame. A read of 0x09 returns 0x00.
- R9: sw_rst_o falls at the first SCLK rising edge or chip-select rising edge after it was raised.
- R10: An instruction byte other than 0x01..0x04 aborts the frame. No register changes and MISO is not driven until chip select goes high.
- R11: spi_miso_oe_o is low while chip select is high and outside read-data bytes.
- R12: After rst_n, every stored register is 0x00, and both spi_miso_oe_o and sw_rst_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk_i | input | 1 | Serial clock from the controller |
| spi_cs_n_i | input | 1 | Active-low chip select |
| spi_mosi_i | input | 1 | Serial data from the controller |
| spi_miso_o | output | 1 | Serial read data to the controller |
| spi_miso_oe_o | output | 1 | High when spi_miso_o should be driven onto the pin |
| cfg_o | output | 208 | Stored registers; byte k holds address 0x0A+k |
| sw_rst_o | output | 1 | Software reset level raised by a write to 0x09 |

## Verification
The main function is exercised with a lone single write, single writes chained in one frame, a burst write across four addresses, and single reads of stored, unstored and reset addresses. Comparing chained against lone writes shows whether the instruction phase is re-entered after a single access. A burst read that starts at 0xFE, with MOSI carrying a valid-looking instruction pattern throughout, separates correct wrap-around and input masking from address restarts or stray writes. Two software-reset frames, one closed by chip select and one continued with a further SCLK pulse, tell the two release paths apart and confirm that the rest of the frame is aborted.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;

  typedef enum logic [1:0] {
    PH_INSTR = 2'd0,
    PH_ADDR  = 2'd1,
    PH_DATA  = 2'd2,
    PH_ABORT = 2'd3
  } phase_e;

  localparam int OP_WR_ONE = 32'h01;
  localparam int OP_RD_ONE = 32'h02;
  localparam int OP_WR_RUN = 32'h03;
  localparam int OP_RD_RUN = 32'h04;

  function automatic logic op_known(input logic [31:0] op);
    return (op == OP_WR_ONE) || (op == OP_RD_ONE) || (op == OP_WR_RUN) || (op == OP_RD_RUN);
  endfunction

  function automatic logic op_is_read(input logic [31:0] op);
    return (op == OP_RD_ONE) || (op == OP_RD_RUN);
  endfunction

  function automatic logic op_is_run(input logic [31:0] op);
    return (op == OP_WR_RUN) || (op == OP_RD_RUN);
  endfunction

  // Address lies inside [lo, hi]
  function automatic logic addr_within(input logic [31:0] a, input int lo, input int hi);
    return (a >= 32'(lo)) && (a <= 32'(hi));
  endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic cs_n_i,
  input  logic mosi_i,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_rise,
  output logic cs_act,
  output logic mosi_s
);

  logic [STAGES:0]   sclk_p;
  logic [STAGES:0]   csn_p;
  logic [STAGES-1:0] mosi_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_p <= '0;
      csn_p  <= '1;
      mosi_p <= '0;
    end else begin
      sclk_p <= {sclk_p[STAGES-1:0], sclk_i};
      csn_p  <= {csn_p[STAGES-1:0], cs_n_i};
      mosi_p <= {mosi_p[STAGES-2:0], mosi_i};
    end
  end

  assign sclk_rise = sclk_p[STAGES-1] & ~sclk_p[STAGES];
  assign sclk_fall = ~sclk_p[STAGES-1] & sclk_p[STAGES];
  assign cs_rise   = csn_p[STAGES-1] & ~csn_p[STAGES];
  assign cs_act    = ~csn_p[STAGES-1];
  assign mosi_s    = mosi_p[STAGES-1];

endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
  import spi_cfg_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sclk_rise,
  input  logic         sclk_fall,
  input  logic         cs_act,
  input  logic         mosi,
  input  logic         sw_rst,
  input  logic [W-1:0] rd_data,
  output logic [W-1:0] rd_addr,
  output logic         wr_stb,
  output logic [W-1:0] wr_addr,
  output logic [W-1:0] wr_data,
  output logic         miso_q,
  output logic         miso_oe
);

  localparam int CW = $clog2(W);

  phase_e         phase_q;
  logic [CW-1:0]  bit_q;
  logic [W-1:0]   sh_q;
  logic [W-1:0]   op_q;
  logic [W-1:0]   addr_q;
  logic [W-1:0]   tx_q;
  logic           tx_pend_q;

  // Named internal events
  wire [W-1:0] byte_in   = {sh_q[W-2:0], mosi};
  wire         live      = cs_act && !sw_rst;
  wire         bit_take  = live && sclk_rise && (phase_q != PH_ABORT);
  wire         byte_done = bit_take && (bit_q == CW'(W - 1));
  wire         op_rd     = op_is_read(32'(op_q));
  wire         op_run    = op_is_run(32'(op_q));
  wire         rd_shift  = live && sclk_fall && (phase_q == PH_DATA) && op_rd;

  assign rd_addr = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_INSTR;
      bit_q     <= '0;
      sh_q      <= '0;
      op_q      <= '0;
      addr_q    <= '0;
      tx_q      <= '0;
      tx_pend_q <= 1'b0;
      wr_stb    <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      miso_q    <= 1'b0;
      miso_oe   <= 1'b0;
    end else begin
      wr_stb <= 1'b0;
      if (tx_pend_q) begin
        tx_q      <= rd_data;
        tx_pend_q <= 1'b0;
      end
      if (!cs_act) begin
        phase_q   <= PH_INSTR;
        bit_q     <= '0;
        miso_oe   <= 1'b0;
        tx_pend_q <= 1'b0;
      end else if (sw_rst) begin
        phase_q <= PH_ABORT;
        miso_oe <= 1'b0;
      end else begin
        if (bit_take) begin
          sh_q  <= byte_in;
          bit_q <= byte_done ? '0 : bit_q + 1'b1;
        end
        if (byte_done) begin
          case (phase_q)
            PH_INSTR: begin
              if (op_known(32'(byte_in))) begin
                op_q    <= byte_in;
                phase_q <= PH_ADDR;
              end else begin
                phase_q <= PH_ABORT;
              end
            end
            PH_ADDR: begin
              addr_q    <= byte_in;
              phase_q   <= PH_DATA;
              tx_pend_q <= op_rd;
            end
            PH_DATA: begin
              if (!op_rd) begin
                wr_stb  <= 1'b1;
                wr_addr <= addr_q;
                wr_data <= byte_in;
              end
              if (op_run) begin
                addr_q    <= addr_q + 1'b1;
                tx_pend_q <= op_rd;
              end else begin
                phase_q <= PH_INSTR;
              end
            end
            default: phase_q <= PH_ABORT;
          endcase
        end
        if (sclk_fall) begin
          if (rd_shift) begin
            miso_q  <= tx_q[W-1];
            tx_q    <= {tx_q[W-2:0], 1'b0};
            miso_oe <= 1'b1;
          end else begin
            miso_oe <= 1'b0;
          end
        end
      end
    end
  end

  AST_ABORT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_ABORT) |=> !wr_stb); // R10
  AST_MISO_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_fall |=> $stable(miso_q)); // R4
  AST_OE_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !miso_oe); // R11
  AST_RUN_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && phase_q == PH_DATA && op_run) |=> (addr_q == W'($past(addr_q) + 1'b1))); // R5

endmodule

// File: rtl/spi_cfg_regs.sv
module spi_cfg_regs
  import spi_cfg_pkg::*;
#(
  parameter int W         = 8,
  parameter int RST_ADDR  = 9,
  parameter int LAST_ADDR = 35,
  localparam int FIRST    = RST_ADDR + 1,
  localparam int NREG     = LAST_ADDR - RST_ADDR
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_stb,
  input  logic [W-1:0]    wr_addr,
  input  logic [W-1:0]    wr_data,
  input  logic [W-1:0]    rd_addr,
  input  logic            sclk_rise,
  input  logic            cs_rise,
  output logic [W-1:0]    rd_data,
  output logic [NREG*W-1:0] cfg_o,
  output logic            srst_o
);

  logic [W-1:0] regs_q [NREG];
  logic         srst_q;

  wire srst_hit   = wr_stb && (wr_addr == W'(RST_ADDR));
  wire srst_free  = sclk_rise || cs_rise;
  wire wr_outside = wr_stb && !addr_within(32'(wr_addr), RST_ADDR, LAST_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          srst_q <= 1'b0;
    else if (srst_hit)   srst_q <= 1'b1;
    else if (srst_free)  srst_q <= 1'b0;
  end

  assign srst_o = srst_q;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs_q[g] <= '0;
      else if (srst_hit || srst_q)
        regs_q[g] <= '0;
      else if (wr_stb && wr_addr == W'(FIRST + g))
        regs_q[g] <= wr_data;
    end
    assign cfg_o[g*W +: W] = regs_q[g];
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NREG; i++) begin
      if (rd_addr == W'(FIRST + i)) rd_data = regs_q[i];
    end
  end

  AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    srst_hit |=> (cfg_o == '0)); // R8
  AST_OUTSIDE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_outside && !srst_q) |=> $stable(cfg_o)); // R7
  AST_SRST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (srst_q && !srst_hit && srst_free) |=> !srst_q); // R9

endmodule

// File: rtl/spi_cfg_slave.sv
module spi_cfg_slave
  import spi_cfg_pkg::*;
#(
  parameter int W          = 8,
  parameter int SYNC       = 2,
  parameter int RST_ADDR   = 9,
  parameter int LAST_ADDR  = 35,
  localparam int NREG      = LAST_ADDR - RST_ADDR
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk_i,
  input  logic              spi_cs_n_i,
  input  logic              spi_mosi_i,
  output logic              spi_miso_o,
  output logic              spi_miso_oe_o,
  output logic [NREG*W-1:0] cfg_o,
  output logic              sw_rst_o
);

  logic         sclk_rise, sclk_fall, cs_rise, cs_act, mosi_s;
  logic         wr_stb;
  logic [W-1:0] wr_addr, wr_data, rd_addr, rd_data;
  logic         srst;

  spi_pin_sync #(.STAGES(SYNC)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_i    (spi_sclk_i),
    .cs_n_i    (spi_cs_n_i),
    .mosi_i    (spi_mosi_i),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .cs_rise   (cs_rise),
    .cs_act    (cs_act),
    .mosi_s    (mosi_s)
  );

  spi_frame_ctrl #(.W(W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .cs_act    (cs_act),
    .mosi      (mosi_s),
    .sw_rst    (srst),
    .rd_data   (rd_data),
    .rd_addr   (rd_addr),
    .wr_stb    (wr_stb),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .miso_q    (spi_miso_o),
    .miso_oe   (spi_miso_oe_o)
  );

  spi_cfg_regs #(.W(W), .RST_ADDR(RST_ADDR), .LAST_ADDR(LAST_ADDR)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_stb    (wr_stb),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .sclk_rise (sclk_rise),
    .cs_rise   (cs_rise),
    .rd_data   (rd_data),
    .cfg_o     (cfg_o),
    .srst_o    (srst)
  );

  assign sw_rst_o = srst;

  AST_OE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_act && !$past(cs_act)) |-> !spi_miso_oe_o); // R11
  AST_NO_WRITE_IN_SRST: assert property (@(posedge clk) disable iff (!rst_n)
    srst |-> !(wr_stb && wr_addr != W'(RST_ADDR))); // R8

endmodule

// File: tb/spi_cfg_slave_bench.sv
module spi_cfg_slave_bench;

  localparam int W    = 8;
  localparam int NREG = 26;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0;
  logic cs_n = 1'b1;
  logic mosi = 1'b0;
  logic miso, miso_oe, sw_rst;
  logic [NREG*W-1:0] cfg;

  always #5 clk = ~clk;

  spi_cfg_slave u_spi_cfg_slave (
    .clk           (clk),
    .rst_n         (rst_n),
    .spi_sclk_i    (sclk),
    .spi_cs_n_i    (cs_n),
    .spi_mosi_i    (mosi),
    .spi_miso_o    (miso),
    .spi_miso_oe_o (miso_oe),
    .cfg_o         (cfg),
    .sw_rst_o      (sw_rst)
  );

  int n_chk = 0;
  int n_err = 0;
  int idle_cnt = 0;
  int oe_bad = 0;
  int cfg_bad = 0;
  int cyc = 0;
  logic oe_seen;
  logic [7:0] model [256];
  logic [7:0] rx;

  function automatic logic [NREG*W-1:0] model_vec();
    logic [NREG*W-1:0] v;
    for (int a = 10; a <= 35; a++) v[(a-10)*8 +: 8] = model[a];
    return v;
  endfunction

  function automatic logic [7:0] model_rd(input logic [7:0] a);
    return (a >= 8'h0A && a <= 8'h23) ? model[a] : 8'h00;
  endfunction

  task automatic model_wr(input logic [7:0] a, input logic [7:0] d);
    if (a == 8'h09) begin
      for (int k = 0; k < 256; k++) model[k] = 8'h00;
    end else if (a >= 8'h0A && a <= 8'h23) begin
      model[a] = d;
    end
  endtask

  task automatic chk(input string tag, input logic [NREG*W-1:0] act, input logic [NREG*W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  // Per-clock reference comparison while the bus is idle
  always @(negedge clk) begin
    cyc++;
    if (rst_n && cs_n) idle_cnt++; else idle_cnt = 0;
    if (idle_cnt >= 5) begin
      if (miso_oe !== 1'b0) oe_bad++;
      if (cfg !== model_vec()) cfg_bad++;
    end
    if (cyc == 150000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, 150000);
      finish_run();
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_begin();
    cs_n = 1'b0; oe_seen = 1'b0; wait_clk(HALF);
  endtask

  task automatic cs_end();
    wait_clk(HALF); cs_n = 1'b1; wait_clk(3 * HALF);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      wait_clk(HALF);
      r[i] = miso;
      oe_seen = oe_seen | miso_oe;
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic single_wr(input logic [7:0] a, input logic [7:0] d);
    xfer(8'h01, rx); xfer(a, rx); xfer(d, rx);
    model_wr(a, d);
  endtask

  task automatic single_rd(input logic [7:0] a, output logic [7:0] d);
    xfer(8'h02, rx); xfer(a, rx); xfer(8'h00, d);
  endtask

  initial begin
    logic [7:0] d;
    for (int k = 0; k < 256; k++) model[k] = 8'h00;
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(4);
    // R12 reset state
    chk("R12 cfg after reset", cfg, '0);
    chk("R12 oe after reset", NREG*W'(miso_oe), '0);
    chk("R12 sw_rst after reset", NREG*W'(sw_rst), '0);

    // R1 lone single write
    cs_begin(); single_wr(8'h0A, 8'hA5); cs_end();
    chk("R1 single write 0x0A", cfg, model_vec());

    // R2 chained single writes, including top address (R7 boundary)
    cs_begin(); single_wr(8'h0B, 8'h3C); single_wr(8'h23, 8'h81); cs_end();
    chk("R2 chained writes", cfg, model_vec());

    // R3 burst write
    cs_begin(); xfer(8'h03, rx); xfer(8'h10, rx);
    for (int k = 0; k < 4; k++) begin
      xfer(8'(8'h11 * (k + 1)), rx);
      model_wr(8'(8'h10 + k), 8'(8'h11 * (k + 1)));
    end
    cs_end();
    chk("R3 burst write", cfg, model_vec());

    // R7 writes outside the stored window are dropped
    cs_begin(); single_wr(8'h08, 8'hEE); single_wr(8'h24, 8'hEE); single_wr(8'h30, 8'hEE); cs_end();
    chk("R7 outside writes dropped", cfg, model_vec());

    // R4 single read, R11 oe driven during read data
    cs_begin(); single_rd(8'h10, d); cs_end();
    chk("R4 single read 0x10", NREG*W'(d), NREG*W'(model_rd(8'h10)));
    chk("R11 oe during read", NREG*W'(oe_seen), NREG*W'(1'b1));
    cs_begin(); single_rd(8'h23, d); cs_end();
    chk("R4 single read 0x23", NREG*W'(d), NREG*W'(8'h81));

    // R7 read outside and R8 read of reset address
    cs_begin(); single_rd(8'h30, d); cs_end();
    chk("R7 read outside", NREG*W'(d), '0);
    cs_begin(); single_rd(8'h09, d); cs_end();
    chk("R8 read reset address", NREG*W'(d), '0);

    // R5 burst read wrap, R6 MOSI ignored (garbage looks like write op)
    cs_begin(); xfer(8'h04, rx); xfer(8'hFE, rx);
    for (int k = 0; k < 14; k++) begin
      xfer(8'h01, d);
      chk($sformatf("R5 burst read addr %02h", 8'(8'hFE + k)), NREG*W'(d), NREG*W'(model_rd(8'(8'hFE + k))));
    end
    cs_end();
    chk("R6 cfg unchanged after burst read", cfg, model_vec());

    // R10 invalid instructions abort
    cs_begin(); xfer(8'h07, rx); xfer(8'h0A, rx); xfer(8'hFF, rx); xfer(8'h02, rx); xfer(8'h0A, rx); cs_end();
    chk("R10 invalid op no write", cfg, model_vec());
    chk("R10 invalid op no drive", NREG*W'(oe_seen), '0);
    cs_begin(); xfer(8'h00, rx); xfer(8'h01, rx); xfer(8'h0C, rx); xfer(8'h99, rx); cs_end();
    chk("R10 zero op no write", cfg, model_vec());

    // R8 software reset, released by CS rising (R9)
    cs_begin(); single_wr(8'h09, 8'h5A);
    chk("R8 sw_rst raised", NREG*W'(sw_rst), NREG*W'(1'b1));
    chk("R8 cfg cleared", cfg, '0);
    cs_end();
    chk("R9 sw_rst released by CS", NREG*W'(sw_rst), '0);

    // R8/R9 reset released by SCLK rising, rest of frame aborted
    cs_begin(); single_wr(8'h0D, 8'h42); single_wr(8'h15, 8'h24); cs_end();
    chk("R1 refill before reset", cfg, model_vec());
    cs_begin(); single_wr(8'h09, 8'h00);
    chk("R8 sw_rst raised again", NREG*W'(sw_rst), NREG*W'(1'b1));
    mosi = 1'b0; wait_clk(HALF); sclk = 1'b1; wait_clk(HALF);
    chk("R9 sw_rst released by SCLK", NREG*W'(sw_rst), '0);
    sclk = 1'b0;
    xfer(8'h01, rx); xfer(8'h0D, rx); xfer(8'h77, rx);
    cs_end();
    chk("R8 frame aborted after reset", cfg, model_vec());

    // R11 and idle comparison monitor results
    chk("R11 oe low while idle", NREG*W'(oe_bad), '0);
    chk("R1 idle cfg matches model", NREG*W'(cfg_bad), '0);
    finish_run();
  end

endmodule